// File: doc/BRIEF.md
# Supervisory Reset Generator with Memory Enable Gate

This block produces the reset for a microprocessor and gates its memory chip-enable. Reset is raised by either of two causes: a flag from an external comparator saying the supply is under its threshold, or a low level on a manual-reset pin. Once every cause has gone away, reset stays asserted for a fixed hold time counted in clock cycles, and only then does it release. Any return of a cause while the hold is running throws the count away, and the count starts again from zero once the cause clears.

A power-fail indication that is forced low from outside can mask the manual-reset pin, but only during the first half of the hold. This lets a system reach a sealed low-power state without a stuck manual-reset line extending the reset. The chip-enable gate lets a low enable reach memory only while reset is inactive. If the processor is in the middle of a memory access when reset arrives, the enable stays low for a short grace window, which ends early when the processor lifts its own enable.

The three level inputs pass through synchronizers. An asynchronous power-on reset puts the block in the hold phase with the count at zero. The reset state machine has three states. ST_ASSERT: a cause is present and the count is held at zero. ST_HOLD: no cause is present and the count runs. ST_RUN: reset is released. Its transitions are: assert-to-hold when no cause is present; hold-to-run when the count reaches the last hold cycle; hold-to-assert and run-to-assert when a cause appears. The grace gate has two states. G_IDLE: no grace. G_OPEN: grace is running. Its transitions are: idle-to-open when reset asserts from ST_RUN while the enable input is low; open-to-idle when the enable input goes high or the window has run out.

Top module: `rstgen_ce`

## Requirements
- R1: After the asynchronous power-on reset, rst_n_o is 0, and with no cause present it stays 0 for HOLD_CYCLES clock edges before it releases.
- R2: supply_low_i = 1 asserts reset. The input passes SYNC_STAGES synchronizer flops, and the state register adds one more edge before rst_n_o falls.
- R3: mr_n_i = 0 asserts reset, with the same latency as R2. While the block is idle, mr_n_i is treated as 1.
- R4: Once no cause has been seen at the synchronizer output, rst_n_o rises exactly HOLD_CYCLES+1 edges after the edge on which the cause was last seen. It never rises after fewer than HOLD_CYCLES consecutive cycles low.
- R5: A cause that returns while the hold is running sends the machine back to ST_ASSERT. The full hold is counted again after the cause clears.
- R6: While pf_low_i = 1 (synchronized) and the hold count is below HOLD_CYCLES/2, mr_n_i = 0 has no effect. From HOLD_CYCLES/2 onward, mr_n_i = 0 restarts the hold as in R5.
- R7: rst_o is always the inverse of rst_n_o.
- R8: ce_n_o is 0 only when ce_n_i is 0 and either reset is inactive or the grace window is open. Outside the grace window, ce_n_o = ce_n_i while reset is inactive and ce_n_o = 1 while reset is active.
- R9: When reset asserts from ST_RUN on an edge where ce_n_i = 0, ce_n_o stays 0 for GRACE_CYCLES cycles and then goes to 1.
- R10: If ce_n_i rises during the grace window, the window closes. ce_n_o stays 1 for the rest of that reset, even if ce_n_i returns to 0.
- R11: When reset asserts while ce_n_i = 1, no grace window opens. Re-entering ST_ASSERT from ST_HOLD opens no window either.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| arst_n | input | 1 | Asynchronous power-on reset, active low |
| supply_low_i | input | 1 | 1 when the supply is below the reset threshold |
| mr_n_i | input | 1 | Manual reset, active low |
| pf_low_i | input | 1 | 1 when the power-fail output is held low from outside |
| ce_n_i | input | 1 | Chip-enable from the processor, active low |
| rst_n_o | output | 1 | Reset, active low |
| rst_o | output | 1 | Reset, active high |
| ce_n_o | output | 1 | Gated chip-enable to memory, active low |

## Verification
On every cycle, the assertions check the following:
- rst_o is the inverse of rst_n_o.
- A synchronized supply-low flag forces reset on the next edge.
- Reset never releases before a full hold of consecutive low cycles.
- ce_n_o is never low without ce_n_i low.
- A low ce_n_o during reset never lasts longer than the grace window.

Some behaviours only the bench scenarios can show: the exact release cycle, the restart of the hold after a new dip, the manual-reset mask being active in the first half and lifted in the second, and a grace window closing early and staying closed. The bench shows these by comparing every cycle against its behavioural model.

// File: rtl/rstgen_pkg.sv
package rstgen_pkg;
    typedef enum logic [1:0] {
        ST_ASSERT = 2'd0,
        ST_HOLD   = 2'd1,
        ST_RUN    = 2'd2
    } rst_state_e;

    typedef enum logic {
        G_IDLE = 1'b0,
        G_OPEN = 1'b1
    } grace_state_e;
endpackage

// File: rtl/rstgen_sync.sv
module rstgen_sync #(
    parameter int STAGES    = 2,
    parameter bit RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic arst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge arst_n) begin
                if (!arst_n) chain_q <= RESET_VAL;
                else         chain_q <= d_i;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge arst_n) begin
                if (!arst_n) chain_q <= {STAGES{RESET_VAL}};
                else         chain_q <= {chain_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rstgen_fsm.sv
module rstgen_fsm
    import rstgen_pkg::*;
#(
    parameter int HOLD_CYCLES = 8
) (
    input  logic clk,
    input  logic arst_n,
    input  logic supply_low_s,
    input  logic mr_low_s,
    input  logic pf_low_s,
    output logic rst_active,
    output logic assert_now
);
    localparam int CNT_W = $clog2(HOLD_CYCLES + 1);
    localparam int HALF  = HOLD_CYCLES / 2;

    rst_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             mr_masked, cause;

    assign mr_masked = pf_low_s && (state_q == ST_HOLD) && (cnt_q < CNT_W'(HALF));
    assign cause     = supply_low_s || (mr_low_s && !mr_masked);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_ASSERT: begin
                cnt_d = '0;
                if (!cause) state_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (cause) begin
                    state_d = ST_ASSERT;
                    cnt_d   = '0;
                end else if (cnt_q == CNT_W'(HOLD_CYCLES - 1)) begin
                    state_d = ST_RUN;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_RUN: begin
                if (cause) state_d = ST_ASSERT;
            end
            default: begin
                state_d = ST_ASSERT;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            state_q <= ST_HOLD;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        rst_active = (state_q != ST_RUN);
        assert_now = (state_q == ST_RUN) && cause;
    end
endmodule

// File: rtl/rstgen_ce_gate.sv
module rstgen_ce_gate
    import rstgen_pkg::*;
#(
    parameter int GRACE_CYCLES = 4
) (
    input  logic clk,
    input  logic arst_n,
    input  logic assert_now,
    input  logic rst_active,
    input  logic ce_n_i,
    output logic ce_n_o
);
    localparam int GCNT_W = $clog2(GRACE_CYCLES + 1);

    grace_state_e      gstate_q, gstate_d;
    logic [GCNT_W-1:0] gcnt_q, gcnt_d;

    always_comb begin
        gstate_d = gstate_q;
        gcnt_d   = gcnt_q;
        unique case (gstate_q)
            G_IDLE: begin
                if (assert_now && !ce_n_i) begin
                    gstate_d = G_OPEN;
                    gcnt_d   = '0;
                end
            end
            G_OPEN: begin
                if (assert_now && !ce_n_i) begin
                    gcnt_d = '0;
                end else if (ce_n_i || gcnt_q == GCNT_W'(GRACE_CYCLES - 1)) begin
                    gstate_d = G_IDLE;
                    gcnt_d   = '0;
                end else begin
                    gcnt_d = gcnt_q + 1'b1;
                end
            end
            default: gstate_d = G_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            gstate_q <= G_IDLE;
            gcnt_q   <= '0;
        end else begin
            gstate_q <= gstate_d;
            gcnt_q   <= gcnt_d;
        end
    end

    always_comb begin
        ce_n_o = ce_n_i || (rst_active && (gstate_q != G_OPEN));
    end
endmodule

// File: rtl/rstgen_ce.sv
module rstgen_ce #(
    parameter int HOLD_CYCLES  = 20_000_000,
    parameter int GRACE_CYCLES = 1_000,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic arst_n,
    input  logic supply_low_i,
    input  logic mr_n_i,
    input  logic pf_low_i,
    input  logic ce_n_i,
    output logic rst_n_o,
    output logic rst_o,
    output logic ce_n_o
);
    logic supply_low_s, mr_n_s, pf_low_s;
    logic rst_active, assert_now;

    rstgen_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_supply (
        .clk(clk), .arst_n(arst_n), .d_i(supply_low_i), .q_o(supply_low_s));
    rstgen_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_mr (
        .clk(clk), .arst_n(arst_n), .d_i(mr_n_i), .q_o(mr_n_s));
    rstgen_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sync_pf (
        .clk(clk), .arst_n(arst_n), .d_i(pf_low_i), .q_o(pf_low_s));

    rstgen_fsm #(.HOLD_CYCLES(HOLD_CYCLES)) u_fsm (
        .clk(clk), .arst_n(arst_n),
        .supply_low_s(supply_low_s), .mr_low_s(!mr_n_s), .pf_low_s(pf_low_s),
        .rst_active(rst_active), .assert_now(assert_now));

    rstgen_ce_gate #(.GRACE_CYCLES(GRACE_CYCLES)) u_gate (
        .clk(clk), .arst_n(arst_n),
        .assert_now(assert_now), .rst_active(rst_active),
        .ce_n_i(ce_n_i), .ce_n_o(ce_n_o));

    assign rst_n_o = !rst_active;
    assign rst_o   = rst_active;
endmodule

// File: rtl/rstgen_ce_chk.sv
module rstgen_ce_chk #(
    parameter int HOLD_CYCLES  = 8,
    parameter int GRACE_CYCLES = 4
) (
    input logic clk,
    input logic arst_n,
    input logic supply_low_s,
    input logic ce_n_i,
    input logic rst_n_o,
    input logic rst_o,
    input logic ce_n_o
);
    localparam int LW = $clog2(HOLD_CYCLES + 2);
    localparam int GW = $clog2(GRACE_CYCLES + 2);

    logic [LW-1:0] lowrun;
    logic [GW-1:0] glow;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            lowrun <= '0;
            glow   <= '0;
        end else begin
            if (rst_n_o) lowrun <= '0;
            else if (lowrun < LW'(HOLD_CYCLES)) lowrun <= lowrun + 1'b1;
            if (!rst_n_o && !ce_n_o) begin
                if (glow <= GW'(GRACE_CYCLES)) glow <= glow + 1'b1;
            end else begin
                glow <= '0;
            end
        end
    end

    a_r7_inverse: assert property (@(posedge clk) disable iff (!arst_n)
        rst_o != rst_n_o);
    a_r2_supply_forces: assert property (@(posedge clk) disable iff (!arst_n)
        supply_low_s |=> !rst_n_o);
    a_r4_min_hold: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(rst_n_o) |-> (lowrun >= LW'(HOLD_CYCLES)));
    a_r8_ce_needs_input: assert property (@(posedge clk) disable iff (!arst_n)
        !ce_n_o |-> !ce_n_i);
    a_r9_grace_bound: assert property (@(posedge clk) disable iff (!arst_n)
        glow <= GW'(GRACE_CYCLES));
endmodule

bind rstgen_ce rstgen_ce_chk #(.HOLD_CYCLES(HOLD_CYCLES), .GRACE_CYCLES(GRACE_CYCLES)) u_chk (
    .clk(clk), .arst_n(arst_n), .supply_low_s(supply_low_s), .ce_n_i(ce_n_i),
    .rst_n_o(rst_n_o), .rst_o(rst_o), .ce_n_o(ce_n_o));

// File: tb/rstgen_ce_bench.sv
module rstgen_ce_bench;
    localparam int HOLD  = 8;
    localparam int GRACE = 3;

    logic clk = 1'b0;
    logic arst_n = 1'b0;
    logic supply_low_i = 1'b0, mr_n_i = 1'b1, pf_low_i = 1'b0, ce_n_i = 1'b1;
    logic rst_n_o, rst_o, ce_n_o;

    int n_tests = 0;
    int n_fail  = 0;
    string phase = "R1 power-on";
    bit done = 1'b0;

    always #5 clk = ~clk;

    rstgen_ce #(.HOLD_CYCLES(HOLD), .GRACE_CYCLES(GRACE), .SYNC_STAGES(2)) u_rstgen_ce (
        .clk(clk), .arst_n(arst_n), .supply_low_i(supply_low_i), .mr_n_i(mr_n_i),
        .pf_low_i(pf_low_i), .ce_n_i(ce_n_i),
        .rst_n_o(rst_n_o), .rst_o(rst_o), .ce_n_o(ce_n_o));

    // behavioural reference: quiet = cycles without a cause, grace_left = cycles of grace remaining
    int quiet, grace_left;
    bit sup1, sup2, mr1, mr2, pf1, pf2;

    always @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            quiet = 1; grace_left = 0;
            sup1 = 1; sup2 = 1; mr1 = 1; mr2 = 1; pf1 = 0; pf2 = 0;
        end else begin
            bit masked, cause, was_rel, now_rel;
            masked  = pf2 && quiet >= 1 && quiet <= HOLD / 2;
            cause   = sup2 || (!mr2 && !masked);
            was_rel = (quiet >= HOLD + 1);
            if (cause) quiet = 0;
            else if (quiet < HOLD + 1) quiet = quiet + 1;
            now_rel = (quiet >= HOLD + 1);
            if (was_rel && !now_rel) grace_left = ce_n_i ? 0 : GRACE;
            else if (grace_left > 0) grace_left = ce_n_i ? 0 : grace_left - 1;
            sup2 = sup1; sup1 = supply_low_i;
            mr2 = mr1;   mr1 = mr_n_i;
            pf2 = pf1;   pf1 = pf_low_i;
        end
    end

    task automatic check(string tag, logic act, logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (arst_n && !done) begin
            logic m_rst_n, m_ce;
            m_rst_n = (quiet >= HOLD + 1);
            m_ce    = ce_n_i | (!m_rst_n & (grace_left == 0));
            check({phase, " rst_n_o"}, rst_n_o, m_rst_n);
            check({phase, " R7 rst_o"}, rst_o, !m_rst_n);
            check({phase, " R8 ce_n_o"}, ce_n_o, m_ce);
        end
    end

    task automatic cyc(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #200_000;
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: power-on hold
        cyc(3);
        arst_n = 1'b1;
        #2;
        check("R1 reset state", rst_n_o, 1'b0);
        cyc(HOLD + 6);
        check("R1 released after hold", rst_n_o, 1'b1);

        // R2 + R9: supply dip during an access, grace runs out
        phase = "R2 R9 supply dip grace";
        ce_n_i = 1'b0;
        supply_low_i = 1'b1; cyc(1); supply_low_i = 1'b0;
        cyc(3);
        check("R2 reset asserted", rst_n_o, 1'b0);
        check("R9 grace holds enable", ce_n_o, 1'b0);
        cyc(GRACE);
        check("R9 grace expired", ce_n_o, 1'b1);
        phase = "R4 hold release";
        cyc(HOLD + 4);
        check("R4 released", rst_n_o, 1'b1);

        // R3 + R11: manual reset with enable idle
        phase = "R3 R11 manual reset";
        ce_n_i = 1'b1;
        mr_n_i = 1'b0; cyc(3); ce_n_i = 1'b0; cyc(1);
        check("R11 no grace when idle at assert", ce_n_o, 1'b1);
        mr_n_i = 1'b1;
        cyc(HOLD + 5);

        // R5: re-dip during hold restarts
        phase = "R5 re-dip restart";
        ce_n_i = 1'b1;
        supply_low_i = 1'b1; cyc(2); supply_low_i = 1'b0;
        cyc(6);
        supply_low_i = 1'b1; cyc(1); supply_low_i = 1'b0;
        cyc(HOLD);
        check("R5 still held after restart", rst_n_o, 1'b0);
        cyc(6);

        // R6: mask in first half, honoured in second half
        phase = "R6 manual mask";
        mr_n_i = 1'b0; cyc(2); mr_n_i = 1'b1;
        pf_low_i = 1'b1;
        cyc(3);
        mr_n_i = 1'b0; cyc(1); mr_n_i = 1'b1;
        cyc(HOLD - 1);
        mr_n_i = 1'b0; cyc(1); mr_n_i = 1'b1;
        cyc(HOLD + 5);
        pf_low_i = 1'b0;
        cyc(3);

        // R10: grace closes early and stays closed
        phase = "R10 grace early close";
        ce_n_i = 1'b0;
        mr_n_i = 1'b0; cyc(3);
        ce_n_i = 1'b1; cyc(1);
        ce_n_i = 1'b0; cyc(1);
        check("R10 stays closed", ce_n_o, 1'b1);
        mr_n_i = 1'b1;
        cyc(HOLD + 5);

        // R8: gate follows enable while released
        phase = "R8 pass-through";
        for (int i = 0; i < 6; i++) begin
            ce_n_i = i[0];
            cyc(1);
        end
        check("R8 passes low enable", ce_n_o, ce_n_i);
        cyc(2);
        finish_run();
    end
endmodule